// File: doc/BRIEF.md
# Selectable-Source Microsecond Timebase Generator

The block turns one of four reference enables into a family of periodic one-cycle tick strobes: a base 1 us tick, ticks at 10 us, 100 us and 1 ms, and a crystal-style divided tick. All references are modelled as clock enables in a single clock domain. A 32-bit control word, written through a simple write strobe, selects the reference and holds a separate count field for each reference. The base tick fires once every `count` selected-reference enables. Three decade stages, each counting the next-faster tick, derive the longer ticks. On the slow real-time reference (about 32 kHz divided by 32), the same chain gives 1 ms, 10 ms, 100 ms and 1 s periods.

A small sequencer owns the control word and has three states. `ST_ALIGN` holds every counter at zero for one cycle. `ST_RUN` lets the counters advance. `ST_PARK` keeps the block silent when a system-clock path is selected but the system-path enable bit is clear. The transitions are as follows. Reset enters `ST_ALIGN`. `ST_ALIGN` moves to `ST_PARK` when the new word is gated and to `ST_RUN` otherwise. A write in any state, including `ST_ALIGN` itself, returns to `ST_ALIGN`.

Top module: `tbase_gen`

## Requirements
- R1: Control bits [16:15] pick the reference: 0 oscillator (`osc_en`), 1 system narrow path (`sys_en`), 2 system wide path (`sys_en`), 3 real-time clock (`rtc_en`); enables of unselected references advance nothing.
- R2: With source 0, the 1 us tick fires on every N-th `osc_en`, N being bits [7:0]; a value of 0 or 1 gives a tick on every enable.
- R3: With source 1, N is bits [23:19] (5 bits, for system clocks below 32 MHz) and the wide-path field is ignored.
- R4: With source 2, N is bits [31:24] (8 bits, for system clocks below 256 MHz).
- R5: With source 1 or 2 and bit 17 clear, no tick output ever fires.
- R6: With source 3, N is bits [13:8], so 2000 `rtc_en` pulses at N=2 yield 1000, 100, 10 and 1 ticks on the four decade outputs.
- R7: The 10 us, 100 us and 1 ms ticks each fire on every tenth tick of the next-faster output, in the same cycle as that tick.
- R8: `tick_xtal` fires on every third selected enable for sources 0 and 3, and equals the 1 us tick for sources 1 and 2.
- R9: A write clears all counters; selected enables in the write cycle and the cycle after it are ignored, and counting resumes on the enable of the second cycle after the write.
- R10: Each tick is registered: it is high for exactly one clock cycle, in the cycle after the clock edge that sampled the enable that completed the period.
- R11: After reset all ticks are low and the control word selects the oscillator with N=24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word value |
| osc_en | input | 1 | Oscillator reference enable |
| sys_en | input | 1 | System clock reference enable |
| rtc_en | input | 1 | Real-time clock reference enable |
| tick_1us | output | 1 | Base tick |
| tick_10us | output | 1 | Base tick divided by 10 |
| tick_100us | output | 1 | Base tick divided by 100 |
| tick_1ms | output | 1 | Base tick divided by 1000 |
| tick_xtal | output | 1 | Crystal-style divided tick |

## Verification
The hardest case to reach is the 1 ms stage, which needs a thousand base ticks. It must also be shown to line up exactly with the faster stages after a restart. The stimulus reaches it by selecting the real-time source with a count of 2 and driving 2000 isolated enables, then comparing the total on every output. The restart rule is forced by holding the enable high across the write cycle and the following cycle, and by rewriting an unchanged word in mid-period. Either way, a stale count would show up as a tick one enable early.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int CFG_W        = 32;
    localparam int OSC_LSB      = 0;
    localparam int OSC_W        = 8;
    localparam int RTC_LSB      = 8;
    localparam int RTC_W        = 6;
    localparam int SRC_LSB      = 15;
    localparam int SYS_GATE_BIT = 17;
    localparam int NAR_LSB      = 19;
    localparam int NAR_W        = 5;
    localparam int WIDE_LSB     = 24;
    localparam int WIDE_W       = 8;

    typedef enum logic [1:0] {
        SRC_OSC      = 2'd0,
        SRC_SYS_NAR  = 2'd1,
        SRC_SYS_WIDE = 2'd2,
        SRC_RTC      = 2'd3
    } tb_src_e;

    typedef enum logic [1:0] {
        ST_ALIGN = 2'd0,
        ST_RUN   = 2'd1,
        ST_PARK  = 2'd2
    } seq_state_e;

    typedef struct packed {
        tb_src_e              src;
        logic                 sys_gate;
        logic [OSC_W-1:0]     osc_cnt;
        logic [RTC_W-1:0]     rtc_cnt;
        logic [NAR_W-1:0]     nar_cnt;
        logic [WIDE_W-1:0]    wide_cnt;
    } tb_cfg_t;

    function automatic tb_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
        tb_cfg_t c;
        c.src      = tb_src_e'(w[SRC_LSB +: 2]);
        c.sys_gate = w[SYS_GATE_BIT];
        c.osc_cnt  = w[OSC_LSB  +: OSC_W];
        c.rtc_cnt  = w[RTC_LSB  +: RTC_W];
        c.nar_cnt  = w[NAR_LSB  +: NAR_W];
        c.wide_cnt = w[WIDE_LSB +: WIDE_W];
        return c;
    endfunction

    function automatic logic is_sys_src(input tb_src_e s);
        return (s == SRC_SYS_NAR) || (s == SRC_SYS_WIDE);
    endfunction

endpackage

// File: rtl/tbase_seq.sv
module tbase_seq
    import tbase_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_WORD = 32'h0000_0018
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output tb_cfg_t          cfg,
    output logic             count_en,
    output logic             clear
);

    seq_state_e state_q;
    seq_state_e state_d;
    tb_cfg_t    cfg_q;
    logic       gated;

    // control word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= cfg_unpack(RESET_WORD);
        end else if (cfg_we) begin
            cfg_q <= cfg_unpack(cfg_wdata);
        end
    end

    assign gated = is_sys_src(cfg_q.src) && !cfg_q.sys_gate;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ALIGN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ALIGN: begin
                if (cfg_we)     state_d = ST_ALIGN;
                else if (gated) state_d = ST_PARK;
                else            state_d = ST_RUN;
            end
            ST_RUN: begin
                if (cfg_we) state_d = ST_ALIGN;
            end
            ST_PARK: begin
                if (cfg_we) state_d = ST_ALIGN;
            end
            default: state_d = ST_ALIGN;
        endcase
    end

    // outputs
    always_comb begin
        count_en = 1'b0;
        clear    = cfg_we;
        unique case (state_q)
            ST_ALIGN: clear    = 1'b1;
            ST_RUN:   count_en = !cfg_we;
            ST_PARK:  count_en = 1'b0;
            default:  clear    = 1'b1;
        endcase
    end

    assign cfg = cfg_q;

    p_write_aligns_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (state_q == ST_ALIGN));

    p_park_when_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> !gated);

endmodule

// File: rtl/tbase_prescale.sv
module tbase_prescale
    import tbase_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int XTAL_DIV = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  tb_cfg_t cfg,
    input  logic    count_en,
    input  logic    clear,
    input  logic    osc_en,
    input  logic    sys_en,
    input  logic    rtc_en,
    output logic    ref_en,
    output logic    base_tick,
    output logic    xtal_tick
);

    localparam int XW = (XTAL_DIV > 1) ? $clog2(XTAL_DIV) : 1;

    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] base_cnt;
    logic             step;

    // reference and period selection
    always_comb begin
        unique case (cfg.src)
            SRC_OSC: begin
                ref_en = osc_en;
                limit  = CNT_W'(cfg.osc_cnt);
            end
            SRC_SYS_NAR: begin
                ref_en = sys_en;
                limit  = CNT_W'(cfg.nar_cnt);
            end
            SRC_SYS_WIDE: begin
                ref_en = sys_en;
                limit  = CNT_W'(cfg.wide_cnt);
            end
            default: begin
                ref_en = rtc_en;
                limit  = CNT_W'(cfg.rtc_cnt);
            end
        endcase
    end

    assign last = (limit <= CNT_W'(1)) ? '0 : limit - CNT_W'(1);
    assign step = count_en && ref_en;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            base_cnt <= '0;
        end else if (step) begin
            base_cnt <= (base_cnt == last) ? '0 : base_cnt + CNT_W'(1);
        end
    end

    assign base_tick = step && (base_cnt == last);

    generate
        if (XTAL_DIV > 1) begin : g_xtal_div
            logic [XW-1:0] x_cnt;
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    x_cnt <= '0;
                end else if (step) begin
                    x_cnt <= (x_cnt == XW'(XTAL_DIV - 1)) ? '0 : x_cnt + XW'(1);
                end
            end
            assign xtal_tick = is_sys_src(cfg.src) ? base_tick
                             : (step && (x_cnt == XW'(XTAL_DIV - 1)));

            p_xtal_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
                clear |=> (x_cnt == '0));
        end else begin : g_xtal_pass
            assign xtal_tick = is_sys_src(cfg.src) ? base_tick : step;
        end
    endgenerate

    p_base_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (base_cnt == '0));

    p_base_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count_en |-> (base_cnt <= last));

endmodule

// File: rtl/tbase_decade.sv
module tbase_decade #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick_i,
    output logic tick_o
);

    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] TOP = DW'(DIV - 1);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + DW'(1);
        end
    end

    assign tick_o = tick_i && (cnt_q == TOP);

    p_decade_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (cnt_q == TOP) && !clear) |=> (cnt_q == '0));

    p_decade_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/tbase_gen.sv
module tbase_gen
    import tbase_pkg::*;
#(
    parameter int               CNT_W      = 8,
    parameter int               XTAL_DIV   = 3,
    parameter int               DECADE     = 10,
    parameter logic [CFG_W-1:0] RESET_WORD = 32'h0000_0018
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             osc_en,
    input  logic             sys_en,
    input  logic             rtc_en,
    output logic             tick_1us,
    output logic             tick_10us,
    output logic             tick_100us,
    output logic             tick_1ms,
    output logic             tick_xtal
);

    localparam int STAGES = 3;
    localparam int NTICK  = STAGES + 1;

    tb_cfg_t          cfg;
    logic             count_en;
    logic             clear;
    logic             ref_en;
    logic             xtal_c;
    logic [NTICK-1:0] chain;
    logic [NTICK-1:0] tick_q;
    logic             xtal_q;

    tbase_seq #(.RESET_WORD(RESET_WORD)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .cfg      (cfg),
        .count_en (count_en),
        .clear    (clear)
    );

    tbase_prescale #(.CNT_W(CNT_W), .XTAL_DIV(XTAL_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .count_en (count_en),
        .clear    (clear),
        .osc_en   (osc_en),
        .sys_en   (sys_en),
        .rtc_en   (rtc_en),
        .ref_en   (ref_en),
        .base_tick(chain[0]),
        .xtal_tick(xtal_c)
    );

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            tbase_decade #(.DIV(DECADE)) u_dec (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (clear),
                .tick_i(chain[i]),
                .tick_o(chain[i+1])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            xtal_q <= 1'b0;
        end else begin
            tick_q <= chain;
            xtal_q <= xtal_c;
        end
    end

    assign tick_1us   = tick_q[0];
    assign tick_10us  = tick_q[1];
    assign tick_100us = tick_q[2];
    assign tick_1ms   = tick_q[3];
    assign tick_xtal  = xtal_q;

    p_nested_ticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1ms |-> (tick_100us && tick_10us && tick_1us));

    p_quiet_unless_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(count_en) |-> ((tick_q == '0) && !xtal_q));

    p_tick_follows_ref_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1us || tick_xtal) |-> $past(ref_en));

    p_no_tick_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !tick_1us);

endmodule

// File: tb/tbase_gen_test.sv
module tbase_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        osc_en = 1'b0;
    logic        sys_en = 1'b0;
    logic        rtc_en = 1'b0;
    logic        tick_1us, tick_10us, tick_100us, tick_1ms, tick_xtal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tbase_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .osc_en(osc_en), .sys_en(sys_en), .rtc_en(rtc_en),
        .tick_1us(tick_1us), .tick_10us(tick_10us), .tick_100us(tick_100us),
        .tick_1ms(tick_1ms), .tick_xtal(tick_xtal)
    );

    // word layout from the requirements: [31:24] wide, [23:19] narrow,
    // [17] system gate, [16:15] source, [13:8] rtc, [7:0] oscillator
    function automatic logic [31:0] mkw(input int src, input int gate, input int osc,
                                        input int rtc, input int nar, input int wide);
        return {wide[7:0], nar[4:0], 1'b0, gate[0], src[1:0], 1'b0, rtc[5:0], osc[7:0]};
    endfunction

    typedef struct packed {
        logic [31:0] word;
        logic [1:0]  line;
        logic [15:0] pulses;
        logic [15:0] e1, e10, e100, e1k, ex;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{mkw(0,0,4,0,0,0), 2'd0, 16'd40,   16'd10,   16'd1,   16'd0,  16'd0, 16'd13},
        '{mkw(0,0,4,0,0,0), 2'd1, 16'd40,   16'd0,    16'd0,   16'd0,  16'd0, 16'd0},
        '{mkw(1,1,0,0,3,7), 2'd1, 16'd30,   16'd10,   16'd1,   16'd0,  16'd0, 16'd10},
        '{mkw(1,0,0,0,3,7), 2'd1, 16'd30,   16'd0,    16'd0,   16'd0,  16'd0, 16'd0},
        '{mkw(2,1,0,0,3,5), 2'd1, 16'd50,   16'd10,   16'd1,   16'd0,  16'd0, 16'd10},
        '{mkw(3,0,0,2,0,0), 2'd2, 16'd2000, 16'd1000, 16'd100, 16'd10, 16'd1, 16'd666},
        '{mkw(3,0,0,2,0,0), 2'd0, 16'd30,   16'd0,    16'd0,   16'd0,  16'd0, 16'd0},
        '{mkw(0,0,0,0,0,0), 2'd0, 16'd12,   16'd12,   16'd1,   16'd0,  16'd0, 16'd4},
        '{mkw(2,1,0,0,0,1), 2'd1, 16'd100,  16'd100,  16'd10,  16'd1,  16'd0, 16'd100}
    };

    function automatic string row_tag(input int i);
        case (i)
            0: return "R2/R8";
            1: return "R1";
            2: return "R3/R8";
            3: return "R5";
            4: return "R4";
            5: return "R6/R7/R8";
            6: return "R1";
            7: return "R2";
            default: return "R7/R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // tasks start and end just after a falling edge
    task automatic wr(input logic [31:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(input int line, output logic [4:0] t);
        osc_en = (line == 0); sys_en = (line == 1); rtc_en = (line == 2);
        @(negedge clk);
        t = {tick_xtal, tick_1ms, tick_100us, tick_10us, tick_1us};
        osc_en = 1'b0; sys_en = 1'b0; rtc_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [4:0] t;
        int hits;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state and default oscillator period 24
        check("R11 idle", {59'd0, tick_xtal, tick_1ms, tick_100us, tick_10us, tick_1us}, 64'd0);
        hits = 0;
        for (int k = 0; k < 23; k++) begin
            pulse(0, t);
            if (t[0]) hits++;
        end
        pulse(0, t);
        check("R11 default period", {hits, 31'd0, t[0]}, {32'd0, 32'd1});

        // table walk
        for (int i = 0; i < NV; i++) begin
            int c1, c10, c100, c1k, cx;
            c1 = 0; c10 = 0; c100 = 0; c1k = 0; cx = 0;
            wr(VECS[i].word);
            for (int p = 0; p < int'(VECS[i].pulses); p++) begin
                pulse(int'(VECS[i].line), t);
                c1 += t[0]; c10 += t[1]; c100 += t[2]; c1k += t[3]; cx += t[4];
            end
            check(row_tag(i),
                  {c1[15:0], c10[15:0], c100[15:0], c1k[7:0], cx[7:0]},
                  {VECS[i].e1, VECS[i].e10, VECS[i].e100, VECS[i].e1k[7:0], VECS[i].ex[7:0]});
        end

        // R10: enable held high, period 3, one-cycle ticks on every third cycle
        wr(mkw(0,0,3,0,0,0));
        osc_en = 1'b1;
        bad = 0;
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            if (tick_1us !== ((k % 3) == 0)) bad++;
        end
        osc_en = 1'b0;
        @(negedge clk);
        check("R10 one-cycle pattern", 64'(bad), 64'd0);
        check("R10 low after enable stops", {63'd0, tick_1us}, 64'd0);

        // R9: rewrite in mid-period restarts the count
        wr(mkw(0,0,4,0,0,0));
        hits = 0;
        for (int k = 0; k < 3; k++) begin pulse(0, t); hits += t[0]; end
        wr(mkw(0,0,4,0,0,0));
        for (int k = 0; k < 3; k++) begin pulse(0, t); hits += t[0]; end
        pulse(0, t);
        check("R9 restart on rewrite", {hits, 31'd0, t[0]}, {32'd0, 32'd1});

        // R9: enables during write cycle and the align cycle are ignored
        cfg_we = 1'b1; cfg_wdata = mkw(0,0,4,0,0,0); osc_en = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        osc_en = 1'b0;
        hits = 0;
        for (int k = 0; k < 3; k++) begin pulse(0, t); hits += t[0]; end
        pulse(0, t);
        check("R9 enables ignored across write", {hits, 31'd0, t[0]}, {32'd0, 32'd1});

        // R7: tenth base tick coincides with the first 10 us tick
        wr(mkw(0,0,1,0,0,0));
        hits = 0;
        for (int k = 0; k < 9; k++) begin pulse(0, t); hits += t[1]; end
        pulse(0, t);
        check("R7 coincident decade", {hits, 30'd0, t[1], t[0]}, {32'd0, 32'd3});

        // R5: rtc and osc enables also silent while parked
        wr(mkw(1,0,0,0,1,1));
        hits = 0;
        for (int k = 0; k < 10; k++) begin pulse(k % 3, t); hits += int'(t != 5'd0); end
        check("R5 parked silent", 64'(hits), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule